// File: doc/BRIEF.md
# Dead-band edge delay generator

This block turns a single PWM waveform into a complementary pair of gate drives. The high-side output follows the input, but each of its turn-on edges is held back by a programmable rising-edge delay. The low-side output follows the inverted input, and each of its turn-on edges (the input's falling edge) is held back by a separate falling-edge delay. Turn-off edges are never delayed, so there is always a dead interval in which both switches are off.

Both delays are 10-bit counts of time-base units. A time-base unit is the system clock period multiplied by a prescale ratio of 1, 2 or 4. When half-cycle mode is on, a unit is half of a time-base period, which gives twice the resolution. Everything runs on the system clock. Each output channel has its own state machine, and a unit-tick counter inside that channel starts from zero at every input edge. As a result, every delay is an exact number of system clocks.

Each channel state machine has three states: `ST_IDLE` (output off), `ST_HOLD` (counting the dead time) and `ST_DRIVE` (output on). Its transitions are as follows:
- **arm**: from `ST_IDLE` to `ST_HOLD` when the active level appears and the delay is non-zero. The delay and the unit length are latched at this point.
- **pass**: from `ST_IDLE` to `ST_DRIVE` when the active level appears and the delay is zero.
- **expire**: from `ST_HOLD` to `ST_DRIVE` on the last unit tick.
- **abort**: from `ST_HOLD` to `ST_IDLE` when the active level goes away before the count ends.
- **release**: from `ST_DRIVE` to `ST_IDLE` when the active level goes away.

Top module: `deadband_gen`

## Requirements
- R1: While `rst` is high at a clock edge, both outputs are 0 after that edge.
- R2: If `pwm_in` is first sampled high at clock edge k, `out_hi` goes high at edge k + `rise_dly`·U, where U is the unit length in system clocks. A delay of 0 makes `out_hi` go high at edge k itself.
- R3: If `pwm_in` is first sampled low at clock edge k, `out_lo` goes high at edge k + `fall_dly`·U. A delay of 0 makes `out_lo` go high at edge k itself.
- R4: Each output goes low at the first clock edge that samples its active level gone. The active level is `pwm_in` = 1 for `out_hi` and `pwm_in` = 0 for `out_lo`.
- R5: Suppose an active level lasts L sampled edges and L ≤ delay·U. The output for that level then stays low for the whole interval.
- R6: With `half_en` = 0, the unit length U is 1, 2 or 4 clocks for `pre_sel` = 2'b00, 2'b01 or 2'b10. The encoding 2'b11 also gives U = 4.
- R7: With `half_en` = 1, U is half the prescale ratio, so `pre_sel` = 2'b01 gives U = 1 and `pre_sel` = 2'b10 gives U = 2. With `pre_sel` = 2'b00, `half_en` has no effect and U = 1.
- R8: The delay value and U are captured at the input edge that starts a count. Changing `rise_dly`, `fall_dly`, `pre_sel` or `half_en` during a count does not change that count; the new values apply from the next input edge.
- R9: `out_hi` and `out_lo` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_in | input | 1 | PWM input, synchronous to `clk` |
| rise_dly | input | 10 | High-side turn-on delay, in units |
| fall_dly | input | 10 | Low-side turn-on delay, in units |
| pre_sel | input | 2 | Prescale select: 00 gives /1, 01 gives /2, 10 and 11 give /4 |
| half_en | input | 1 | Half-cycle mode: the unit becomes half a time-base period |
| out_hi | output | 1 | High-side gate drive |
| out_lo | output | 1 | Low-side gate drive |

## Verification
The assertions assume that `pwm_in` and the configuration inputs are synchronous to `clk` and stable around its rising edge. They also assume that reset is applied from time zero, so that every channel starts in `ST_IDLE`. The bench meets these assumptions by driving every input on the falling clock edge and by holding reset for several cycles before the first stimulus. The bench changes the configuration only between segments, except in the one test where a mid-count change is the point, so that each expected edge time follows from the values that were latched.

// File: rtl/db_pkg.sv
package db_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_DRIVE = 2'd2
    } db_state_t;
endpackage

// File: rtl/db_unit_len.sv
module db_unit_len #(
    parameter int UNIT_W = 3
) (
    input  logic [1:0]        pre_sel,
    input  logic              half_en,
    output logic [UNIT_W-1:0] unit_o
);
    logic [UNIT_W-1:0] base;

    always_comb begin
        unique case (pre_sel)
            2'b00:   base = UNIT_W'(1);
            2'b01:   base = UNIT_W'(2);
            default: base = UNIT_W'(4);
        endcase
        if (half_en && base > UNIT_W'(1)) begin
            unit_o = base >> 1;
        end else begin
            unit_o = base;
        end
    end
endmodule

// File: rtl/db_tick.sv
module db_tick #(
    parameter int UNIT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic [UNIT_W-1:0] unit_i,
    output logic              tick_o
);
    logic [UNIT_W-1:0] sub;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            sub <= '0;
        end else if (sub == unit_i - UNIT_W'(1)) begin
            sub <= '0;
        end else begin
            sub <= sub + UNIT_W'(1);
        end
    end

    always_comb tick_o = run_i && (sub == unit_i - UNIT_W'(1));

    AST_SUB_BOUND: assert property (@(posedge clk) disable iff (rst)
        run_i |-> (sub < unit_i)); // R6
endmodule

// File: rtl/db_edge_fsm.sv
module db_edge_fsm
    import db_pkg::*;
#(
    parameter int DLY_W  = 10,
    parameter int UNIT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              act_i,
    input  logic [DLY_W-1:0]  dly_i,
    input  logic [UNIT_W-1:0] unit_i,
    input  logic              tick_i,
    output logic              run_o,
    output logic [UNIT_W-1:0] unit_o,
    output logic              on_o
);
    db_state_t         state, state_nxt;
    logic [DLY_W-1:0]  cnt;
    logic [UNIT_W-1:0] unit_lat;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (act_i) begin
                    state_nxt = (dly_i == '0) ? ST_DRIVE : ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (!act_i) begin
                    state_nxt = ST_IDLE;
                end else if (tick_i && cnt == DLY_W'(1)) begin
                    state_nxt = ST_DRIVE;
                end
            end
            ST_DRIVE: begin
                if (!act_i) begin
                    state_nxt = ST_IDLE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            unit_lat <= UNIT_W'(1);
        end else if (state == ST_IDLE && act_i) begin
            cnt      <= dly_i;
            unit_lat <= unit_i;
        end else if (state == ST_HOLD && tick_i) begin
            cnt <= cnt - DLY_W'(1);
        end
    end

    always_comb begin
        on_o   = (state == ST_DRIVE);
        run_o  = (state == ST_HOLD);
        unit_o = unit_lat;
    end

    AST_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && act_i && dly_i == '0) |=> on_o); // R2
    AST_DRIVE_DROPS: assert property (@(posedge clk) disable iff (rst)
        (on_o && !act_i) |=> !on_o); // R4
    AST_RISE_FROM_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        $rose(on_o) |-> $past(act_i)); // R5
    AST_LATCH_KEPT: assert property (@(posedge clk) disable iff (rst)
        (run_o && act_i) |=> $stable(unit_o)); // R8
    AST_COUNT_KEPT: assert property (@(posedge clk) disable iff (rst)
        (run_o && act_i && !tick_i) |=> $stable(cnt)); // R8
endmodule

// File: rtl/deadband_gen.sv
module deadband_gen #(
    parameter int DLY_W   = 10,
    parameter int MAX_DIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwm_in,
    input  logic [DLY_W-1:0] rise_dly,
    input  logic [DLY_W-1:0] fall_dly,
    input  logic [1:0]       pre_sel,
    input  logic             half_en,
    output logic             out_hi,
    output logic             out_lo
);
    localparam int UNIT_W = $clog2(MAX_DIV + 1);
    localparam int N_CH   = 2;

    logic [UNIT_W-1:0] unit_now;
    logic [N_CH-1:0]   act;
    logic [DLY_W-1:0]  dly [N_CH];
    logic [N_CH-1:0]   on;

    always_comb begin
        act[0] = pwm_in;
        act[1] = ~pwm_in;
        dly[0] = rise_dly;
        dly[1] = fall_dly;
    end

    db_unit_len #(.UNIT_W(UNIT_W)) u_unit (
        .pre_sel (pre_sel),
        .half_en (half_en),
        .unit_o  (unit_now)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        logic              run;
        logic              tick;
        logic [UNIT_W-1:0] unit_lat;

        db_edge_fsm #(.DLY_W(DLY_W), .UNIT_W(UNIT_W)) u_fsm (
            .clk    (clk),
            .rst    (rst),
            .act_i  (act[g]),
            .dly_i  (dly[g]),
            .unit_i (unit_now),
            .tick_i (tick),
            .run_o  (run),
            .unit_o (unit_lat),
            .on_o   (on[g])
        );

        db_tick #(.UNIT_W(UNIT_W)) u_tick (
            .clk    (clk),
            .rst    (rst),
            .run_i  (run),
            .unit_i (unit_lat),
            .tick_o (tick)
        );
    end

    always_comb begin
        out_hi = on[0];
        out_lo = on[1];
    end

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(out_hi && out_lo)); // R9
    AST_LO_FROM_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(out_lo) |-> !$past(pwm_in)); // R3
    AST_RESET_OFF: assert property (@(posedge clk)
        rst |=> (!out_hi && !out_lo)); // R1
endmodule

// File: tb/tb_deadband_gen.sv
module tb_deadband_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwm_in = 1'b0;
    logic [9:0] rise_dly = '0;
    logic [9:0] fall_dly = '0;
    logic [1:0] pre_sel = 2'b00;
    logic       half_en = 1'b0;
    logic       out_hi, out_lo;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int overlap = 0;

    typedef struct {
        int    at;
        bit    val;
        string tag;
    } ev_t;

    ev_t q_hi[$];
    ev_t q_lo[$];
    bit  pend_hi = 0, pend_lo = 0;
    string tag_hi = "R4", tag_lo = "R4";
    bit  prev_hi = 0, prev_lo = 0;

    deadband_gen dut (
        .clk(clk), .rst(rst), .pwm_in(pwm_in),
        .rise_dly(rise_dly), .fall_dly(fall_dly),
        .pre_sel(pre_sel), .half_en(half_en),
        .out_hi(out_hi), .out_lo(out_lo)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int unit_len(input logic [1:0] ps, input logic he);
        int b;
        b = (ps == 2'b00) ? 1 : (ps == 2'b01) ? 2 : 4;
        if (he && b > 1) b = b / 2;
        return b;
    endfunction

    task automatic check(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Drive one level for len sampled edges; push expected edges into the scoreboard.
    task automatic seg(input bit lvl, input int len, input string tag,
                       input int chg_at = -1, input int new_r = 0, input int new_f = 0);
        int  t, d, u;
        bit  supp;
        bit  bad;
        ev_t e;
        pwm_in = lvl;
        t = cyc;
        u = unit_len(pre_sel, half_en);
        d = lvl ? int'(rise_dly) : int'(fall_dly);
        if (lvl && pend_lo) begin
            e.at = t + 1; e.val = 0; e.tag = tag_lo; q_lo.push_back(e); pend_lo = 0;
        end
        if (!lvl && pend_hi) begin
            e.at = t + 1; e.val = 0; e.tag = tag_hi; q_hi.push_back(e); pend_hi = 0;
        end
        supp = !(len > d * u);
        if (!supp) begin
            e.at = t + 1 + d * u; e.val = 1; e.tag = tag;
            if (lvl) begin q_hi.push_back(e); pend_hi = 1; tag_hi = tag; end
            else     begin q_lo.push_back(e); pend_lo = 1; tag_lo = tag; end
        end
        bad = 0;
        for (int i = 0; i < len; i++) begin
            if (i == chg_at) begin
                rise_dly = 10'(new_r);
                fall_dly = 10'(new_f);
            end
            @(negedge clk);
            if (supp && (lvl ? out_hi : out_lo)) bad = 1;
        end
        if (supp) check("R5", int'(bad), 0, "suppressed pulse appeared");
    endtask

    task automatic cfg(input int r, input int f, input logic [1:0] ps, input logic he);
        rise_dly = 10'(r);
        fall_dly = 10'(f);
        pre_sel  = ps;
        half_en  = he;
    endtask

    // Monitor: compare every observed output edge with the next expected one.
    always @(negedge clk) begin
        if (!rst) begin
            if (out_hi && out_lo) overlap++;
            if (out_hi != prev_hi) begin
                if (q_hi.size() == 0) begin
                    check("R5", 1, 0, "unexpected out_hi edge");
                end else begin
                    ev_t e;
                    e = q_hi.pop_front();
                    check(e.tag, cyc, e.at, "out_hi edge cycle");
                    check(e.tag, int'(out_hi), int'(e.val), "out_hi edge value");
                end
            end
            if (out_lo != prev_lo) begin
                if (q_lo.size() == 0) begin
                    check("R5", 1, 0, "unexpected out_lo edge");
                end else begin
                    ev_t e;
                    e = q_lo.pop_front();
                    check(e.tag, cyc, e.at, "out_lo edge cycle");
                    check(e.tag, int'(out_lo), int'(e.val), "out_lo edge value");
                end
            end
        end
        prev_hi = out_hi;
        prev_lo = out_lo;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cfg(3, 2, 2'b00, 1'b0);
        pwm_in = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R1", int'(out_hi), 0, "out_hi in reset");
            check("R1", int'(out_lo), 0, "out_lo in reset");
        end
        pwm_in = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        // basic delays, unit 1
        seg(0, 10, "R3");
        seg(1, 12, "R2");
        seg(0, 8, "R3");
        seg(1, 6, "R2");
        // zero delays
        cfg(0, 0, 2'b00, 1'b0);
        seg(0, 5, "R3");
        seg(1, 5, "R2");
        seg(0, 1, "R3");
        seg(1, 1, "R2");
        // suppression at the boundary
        cfg(5, 4, 2'b00, 1'b0);
        seg(0, 4, "R5");
        seg(1, 5, "R5");
        seg(0, 5, "R5");
        seg(1, 6, "R5");
        // prescale ratios
        cfg(3, 2, 2'b01, 1'b0);
        seg(0, 20, "R6");
        seg(1, 20, "R6");
        cfg(3, 2, 2'b10, 1'b0);
        seg(0, 20, "R6");
        seg(1, 20, "R6");
        cfg(3, 2, 2'b11, 1'b0);
        seg(0, 20, "R6");
        seg(1, 12, "R6");
        // half-cycle mode
        cfg(3, 5, 2'b10, 1'b1);
        seg(0, 20, "R7");
        seg(1, 20, "R7");
        cfg(3, 5, 2'b01, 1'b1);
        seg(0, 20, "R7");
        seg(1, 20, "R7");
        cfg(3, 5, 2'b00, 1'b1);
        seg(0, 20, "R7");
        seg(1, 20, "R7");
        // mid-count change keeps the running count
        cfg(4, 3, 2'b10, 1'b0);
        seg(0, 30, "R8", 2, 7, 0);
        seg(1, 30, "R8", 2, 1, 6);
        seg(0, 40, "R8");
        pre_sel = 2'b00;
        seg(1, 20, "R8", 1, 2, 2);
        pre_sel = 2'b10;
        seg(0, 20, "R8");
        // wide delay values
        cfg(1000, 1023, 2'b00, 1'b0);
        seg(1, 1005, "R2");
        seg(0, 1024, "R3");
        seg(1, 30, "R4");
        check("R9", overlap, 0, "cycles with both outputs high");
        check("R4", q_hi.size(), 0, "out_hi expected edges left");
        check("R4", q_lo.size(), 0, "out_lo expected edges left");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule